// File: doc/BRIEF.md
# Sequential Protocol Event Trigger

This block sits behind a storage-bus decoder and watches the decoded events it produces. Each event carries a command index, a flag for a response that did not match, and a flag for a CRC error. The block fires once when the event stream meets a condition that software has programmed. That condition is either a single event or an ordered chain of up to `NUM_STAGES` events. Each stage can match on a masked command index, on the bad-response flag, or on the CRC-error flag.

When the trigger fires, two outputs change together. A one-cycle capture-start strobe tells downstream capture logic to begin recording. A trigger-out pulse of exactly `PULSE_CYCLES` clock cycles drives an external instrument. The default is 20 cycles, which gives 100 ns at 200 MHz.

The `cur_stage` output shows how far a sequential search has advanced, so a run that stalls shows the step where it stopped. After firing, the block disarms itself. It stays quiet until software pulses the arm input again.

Top module: `evt_seq_trigger`

## Requirements
- R1: After reset `trig_out` and `cap_start` are 0, `cur_stage` is 0 and the block is disarmed: matching events cause no trigger until `arm_req` has been pulsed.
- R2: In single mode (`cfg_mode`=0), an armed block fires when an event matches stage 0, whatever `cfg_last_stage` holds. `cap_start` is high for exactly one cycle and `trig_out` rises in that same cycle, on the clock edge after the one that samples the event.
- R3: A stage with its command enable set matches when `((ev_cmd ^ pattern) & mask) == 0`, where a mask bit of 1 means that bit is compared. Stage i takes its pattern and mask from bits `[i*CMD_W +: CMD_W]` of `cfg_cmd_pat` and `cfg_cmd_mask`, and its enables from bit i of `cfg_cmd_en`, `cfg_rsp_en` and `cfg_crc_en`.
- R4: In sequential mode (`cfg_mode`=1), `cur_stage` holds the index of the stage being waited for. A match on that stage advances it by one. A match on stage `cfg_last_stage` fires the trigger and returns `cur_stage` to 0.
- R5: In sequential mode, an event that matches neither the awaited stage nor stage 0 leaves `cur_stage` unchanged. An event that matches stage 0 while a later stage is awaited restarts the sequence with `cur_stage` = 1.
- R6: A stage with `cfg_crc_en` set matches any event with `ev_crc_err`=1. A stage with `cfg_rsp_en` set matches any event with `ev_rsp_bad`=1. A stage whose command enable is 0 ignores the command index.
- R7: Each firing drives `trig_out` high for exactly `PULSE_CYCLES` consecutive cycles.
- R8: After firing, the block is disarmed. Further events, including matching ones during the pulse, raise no `cap_start` and do not lengthen `trig_out`.
- R9: A one-cycle `arm_req` while `trig_out` is low arms the block with `cur_stage` = 0. An `arm_req` while `trig_out` is high has no effect.
- R10: While `cfg_mode` is 0, `cur_stage` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_req | input | 1 | One-cycle request to arm the trigger |
| cfg_mode | input | 1 | 0 = single event, 1 = ordered sequence |
| cfg_last_stage | input | STG_W | Index of the final stage in sequential mode |
| cfg_cmd_pat | input | NUM_STAGES*CMD_W | Command pattern per stage |
| cfg_cmd_mask | input | NUM_STAGES*CMD_W | Compare mask per stage, 1 = compare bit |
| cfg_cmd_en | input | NUM_STAGES | Per-stage enable for command compare |
| cfg_rsp_en | input | NUM_STAGES | Per-stage enable for bad-response match |
| cfg_crc_en | input | NUM_STAGES | Per-stage enable for CRC-error match |
| ev_valid | input | 1 | Decoded event present this cycle |
| ev_cmd | input | CMD_W | Command index of the event |
| ev_rsp_bad | input | 1 | Event carried a response that did not match |
| ev_crc_err | input | 1 | Event carried a CRC error |
| trig_out | output | 1 | Fixed-width trigger pulse |
| cap_start | output | 1 | One-cycle capture-start strobe |
| cur_stage | output | STG_W | Stage currently awaited |

## Verification
Every result of an event is due one clock edge after the edge that samples it. On that edge `cur_stage` updates, `cap_start` rises and `trig_out` rises. `trig_out` then stays high for `PULSE_CYCLES` cycles. The bench drives each event on a falling edge and removes it on the next falling edge. It reads the outputs at that second falling edge, so each result is read exactly one edge after it was caused. The pulse width is counted on successive falling edges, starting from the one where the firing was first seen, and that count includes events injected during the pulse.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

    localparam int CMD_W = 6;

    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_SEQ    = 1'b1
    } trig_mode_e;

    typedef enum logic {
        ARM_OFF = 1'b0,
        ARM_ON  = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic valid;
        cmd_t cmd;
        logic rsp_bad;
        logic crc_err;
    } proto_evt_t;

    typedef struct packed {
        cmd_t pattern;
        cmd_t care;
        logic use_cmd;
        logic use_rsp;
        logic use_crc;
    } stage_cfg_t;

    // A stage is hit when the event is valid and any enabled criterion holds.
    function automatic logic stage_hit(proto_evt_t e, stage_cfg_t c);
        logic cmd_ok;
        logic rsp_ok;
        logic crc_ok;
        cmd_ok = c.use_cmd && (((e.cmd ^ c.pattern) & c.care) == '0);
        rsp_ok = c.use_rsp && e.rsp_bad;
        crc_ok = c.use_crc && e.crc_err;
        return e.valid && (cmd_ok || rsp_ok || crc_ok);
    endfunction

endpackage

// File: rtl/seqtrig_stage_match.sv
module seqtrig_stage_match
    import seqtrig_pkg::*;
#(
    parameter int NUM_STAGES = 4
) (
    input  proto_evt_t                    evt,
    input  stage_cfg_t [NUM_STAGES-1:0]   cfg,
    output logic       [NUM_STAGES-1:0]   hit
);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
        assign hit[g] = stage_hit(evt, cfg[g]);
    end

endmodule

// File: rtl/seqtrig_sequencer.sv
module seqtrig_sequencer
    import seqtrig_pkg::*;
#(
    parameter  int NUM_STAGES = 4,
    localparam int STG_W      = $clog2(NUM_STAGES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm_req,
    input  logic                  pulse_busy,
    input  trig_mode_e            mode,
    input  logic [STG_W-1:0]      last_stage,
    input  logic [NUM_STAGES-1:0] hit,
    output logic                  fire_now,
    output logic                  fire_q,
    output logic [STG_W-1:0]      stage_q
);

    arm_state_e       state_q;
    arm_state_e       state_d;
    logic [STG_W-1:0] stage_d;
    logic [STG_W-1:0] eff_last;
    logic             at_last;

    if ((1 << STG_W) == NUM_STAGES) begin : g_full
        assign eff_last = last_stage;
    end else begin : g_clamp
        localparam logic [STG_W-1:0] TOP_IDX = STG_W'(NUM_STAGES - 1);
        assign eff_last = (last_stage > TOP_IDX) ? TOP_IDX : last_stage;
    end

    assign at_last = (stage_q >= eff_last);

    always_comb begin
        state_d  = state_q;
        stage_d  = stage_q;
        fire_now = 1'b0;
        if (arm_req && !pulse_busy) begin
            state_d = ARM_ON;
            stage_d = '0;
        end else if (state_q == ARM_ON) begin
            if (mode == MODE_SINGLE) begin
                if (hit[0]) begin
                    fire_now = 1'b1;
                    state_d  = ARM_OFF;
                end
            end else if (hit[stage_q]) begin
                if (at_last) begin
                    fire_now = 1'b1;
                    state_d  = ARM_OFF;
                    stage_d  = '0;
                end else begin
                    stage_d = stage_q + 1'b1;
                end
            end else if (hit[0]) begin
                stage_d = STG_W'(1);
            end
        end
        if (mode == MODE_SINGLE) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_OFF;
            stage_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
            fire_q  <= fire_now;
        end
    end

endmodule

// File: rtl/seqtrig_pulse.sv
module seqtrig_pulse #(
    parameter  int PULSE_CYCLES = 20,
    localparam int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse_q
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        if (start && (cnt_q == '0)) begin
            cnt_d = CNT_W'(PULSE_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            pulse_q <= (cnt_d != '0);
        end
    end

endmodule

// File: rtl/evt_seq_trigger.sv
module evt_seq_trigger
    import seqtrig_pkg::*;
#(
    parameter  int NUM_STAGES   = 4,
    parameter  int PULSE_CYCLES = 20,
    localparam int STG_W        = $clog2(NUM_STAGES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm_req,
    input  logic                        cfg_mode,
    input  logic [STG_W-1:0]            cfg_last_stage,
    input  logic [NUM_STAGES*CMD_W-1:0] cfg_cmd_pat,
    input  logic [NUM_STAGES*CMD_W-1:0] cfg_cmd_mask,
    input  logic [NUM_STAGES-1:0]       cfg_cmd_en,
    input  logic [NUM_STAGES-1:0]       cfg_rsp_en,
    input  logic [NUM_STAGES-1:0]       cfg_crc_en,
    input  logic                        ev_valid,
    input  logic [CMD_W-1:0]            ev_cmd,
    input  logic                        ev_rsp_bad,
    input  logic                        ev_crc_err,
    output logic                        trig_out,
    output logic                        cap_start,
    output logic [STG_W-1:0]            cur_stage
);

    proto_evt_t                  evt;
    stage_cfg_t [NUM_STAGES-1:0] stage_cfg;
    logic       [NUM_STAGES-1:0] hit;
    logic                        fire_now;
    logic                        fire_q;
    trig_mode_e                  mode;

    assign evt  = '{valid: ev_valid, cmd: ev_cmd, rsp_bad: ev_rsp_bad, crc_err: ev_crc_err};
    assign mode = trig_mode_e'(cfg_mode);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cfg
        assign stage_cfg[g] = '{
            pattern: cfg_cmd_pat[g*CMD_W +: CMD_W],
            care:    cfg_cmd_mask[g*CMD_W +: CMD_W],
            use_cmd: cfg_cmd_en[g],
            use_rsp: cfg_rsp_en[g],
            use_crc: cfg_crc_en[g]
        };
    end

    seqtrig_stage_match #(.NUM_STAGES(NUM_STAGES)) match_i (
        .evt (evt),
        .cfg (stage_cfg),
        .hit (hit)
    );

    seqtrig_sequencer #(.NUM_STAGES(NUM_STAGES)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .arm_req    (arm_req),
        .pulse_busy (trig_out),
        .mode       (mode),
        .last_stage (cfg_last_stage),
        .hit        (hit),
        .fire_now   (fire_now),
        .fire_q     (fire_q),
        .stage_q    (cur_stage)
    );

    seqtrig_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) pulse_i (
        .clk     (clk),
        .rst     (rst),
        .start   (fire_now),
        .pulse_q (trig_out)
    );

    assign cap_start = fire_q;

endmodule

// File: rtl/evt_seq_trigger_chk.sv
module evt_seq_trigger_chk #(
    parameter  int NUM_STAGES   = 4,
    parameter  int PULSE_CYCLES = 20,
    localparam int STG_W        = $clog2(NUM_STAGES)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_mode,
    input logic             ev_valid,
    input logic             trig_out,
    input logic             cap_start,
    input logic [STG_W-1:0] cur_stage
);

    int unsigned      hi_run;
    logic [STG_W-1:0] prev_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run     <= 0;
            prev_stage <= '0;
        end else begin
            hi_run     <= trig_out ? hi_run + 1 : 0;
            prev_stage <= cur_stage;
        end
    end

    assert_pulse_full_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(trig_out) |-> (hi_run == PULSE_CYCLES));

    assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> (hi_run < PULSE_CYCLES));

    assert_cap_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        cap_start |=> !cap_start);

    assert_cap_with_rise_R2: assert property (@(posedge clk) disable iff (rst)
        cap_start |-> $rose(trig_out));

    assert_cap_after_event_R8: assert property (@(posedge clk) disable iff (rst)
        cap_start |-> $past(ev_valid));

    assert_single_stage_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_mode) == 1'b0) |-> (cur_stage == '0));

    assert_stage_step_R5: assert property (@(posedge clk) disable iff (rst)
        ((cur_stage != prev_stage) && (cur_stage != '0)) |->
        ((cur_stage == STG_W'(prev_stage + 1'b1)) || (cur_stage == STG_W'(1))));

endmodule

bind evt_seq_trigger evt_seq_trigger_chk #(
    .NUM_STAGES   (NUM_STAGES),
    .PULSE_CYCLES (PULSE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .ev_valid  (ev_valid),
    .trig_out  (trig_out),
    .cap_start (cap_start),
    .cur_stage (cur_stage)
);

// File: tb/evt_seq_trigger_tb_top.sv
module evt_seq_trigger_tb_top;
    import seqtrig_pkg::*;

    localparam int NS    = 4;
    localparam int PW    = 20;
    localparam int SW    = $clog2(NS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              arm_req = 1'b0;
    logic              cfg_mode = 1'b0;
    logic [SW-1:0]     cfg_last_stage = '0;
    logic [NS*CMD_W-1:0] cfg_cmd_pat = '0;
    logic [NS*CMD_W-1:0] cfg_cmd_mask = '0;
    logic [NS-1:0]     cfg_cmd_en = '0;
    logic [NS-1:0]     cfg_rsp_en = '0;
    logic [NS-1:0]     cfg_crc_en = '0;
    logic              ev_valid = 1'b0;
    logic [CMD_W-1:0]  ev_cmd = '0;
    logic              ev_rsp_bad = 1'b0;
    logic              ev_crc_err = 1'b0;
    logic              trig_out;
    logic              cap_start;
    logic [SW-1:0]     cur_stage;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    evt_seq_trigger #(.NUM_STAGES(NS), .PULSE_CYCLES(PW)) dut_i (
        .clk(clk), .rst(rst), .arm_req(arm_req), .cfg_mode(cfg_mode),
        .cfg_last_stage(cfg_last_stage), .cfg_cmd_pat(cfg_cmd_pat),
        .cfg_cmd_mask(cfg_cmd_mask), .cfg_cmd_en(cfg_cmd_en),
        .cfg_rsp_en(cfg_rsp_en), .cfg_crc_en(cfg_crc_en),
        .ev_valid(ev_valid), .ev_cmd(ev_cmd), .ev_rsp_bad(ev_rsp_bad),
        .ev_crc_err(ev_crc_err), .trig_out(trig_out), .cap_start(cap_start),
        .cur_stage(cur_stage)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_stage(input int i, input int pat, input int mask,
                             input bit uc, input bit ur, input bit ue);
        cfg_cmd_pat[i*CMD_W +: CMD_W]  = CMD_W'(pat);
        cfg_cmd_mask[i*CMD_W +: CMD_W] = CMD_W'(mask);
        cfg_cmd_en[i] = uc;
        cfg_rsp_en[i] = ur;
        cfg_crc_en[i] = ue;
    endtask

    task automatic clear_stages();
        for (int i = 0; i < NS; i++) set_stage(i, 0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    // Drive one event for one cycle; returns at the falling edge where its result is visible.
    task automatic send(input int cmd, input bit rsp, input bit crc);
        @(negedge clk);
        ev_valid = 1'b1; ev_cmd = CMD_W'(cmd); ev_rsp_bad = rsp; ev_crc_err = crc;
        @(negedge clk);
        ev_valid = 1'b0; ev_rsp_bad = 1'b0; ev_crc_err = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm_req = 1'b1;
        @(negedge clk);
        arm_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && trig_out; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "trig_out after reset", int'(trig_out), 0);
        check("R1", "cap_start after reset", int'(cap_start), 0);
        check("R1", "cur_stage after reset", int'(cur_stage), 0);
        clear_stages();
        cfg_mode = 1'b0;
        set_stage(0, 1, 6'h3F, 1'b1, 1'b0, 1'b0);
        send(1, 1'b0, 1'b0);
        check("R1", "no fire while disarmed", int'(cap_start), 0);
        check("R1", "no pulse while disarmed", int'(trig_out), 0);
    endtask

    task automatic t_single();
        int width;
        clear_stages();
        cfg_mode = 1'b0;
        set_stage(0, 1, 6'h3F, 1'b1, 1'b0, 1'b0);
        do_arm();
        send(5, 1'b0, 1'b0);
        check("R3", "cmd 5 against pattern 1", int'(cap_start), 0);
        send(1, 1'b0, 1'b0);
        check("R2", "cap_start on match", int'(cap_start), 1);
        check("R2", "trig_out rises with cap", int'(trig_out), 1);
        width = 1;
        send(1, 1'b0, 1'b0);
        width += 2;
        check("R8", "no cap during pulse", int'(cap_start), 0);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!trig_out) break;
            width++;
        end
        check("R7", "pulse width", width, PW);
        check("R8", "pulse not extended", width, PW);
        send(1, 1'b0, 1'b0);
        check("R8", "disarmed after fire, cap", int'(cap_start), 0);
        check("R8", "disarmed after fire, trig", int'(trig_out), 0);
    endtask

    task automatic t_mask();
        clear_stages();
        cfg_mode = 1'b0;
        set_stage(0, 6'h01, 6'h03, 1'b1, 1'b0, 1'b0);
        do_arm();
        send(6'h02, 1'b0, 1'b0);
        check("R3", "masked mismatch", int'(cap_start), 0);
        send(6'h21, 1'b0, 1'b0);
        check("R3", "masked match ignores high bits", int'(cap_start), 1);
        wait_idle();
    endtask

    task automatic t_sequence();
        clear_stages();
        cfg_mode = 1'b1;
        cfg_last_stage = SW'(2);
        set_stage(0, 0, 6'h3F, 1'b1, 1'b0, 1'b0);
        set_stage(1, 1, 6'h3F, 1'b1, 1'b0, 1'b0);
        set_stage(2, 6, 6'h3F, 1'b1, 1'b0, 1'b0);
        do_arm();
        check("R9", "stage after arm", int'(cur_stage), 0);
        send(1, 1'b0, 1'b0);
        check("R5", "out of order event keeps stage 0", int'(cur_stage), 0);
        send(0, 1'b0, 1'b0);
        check("R4", "advance to stage 1", int'(cur_stage), 1);
        send(9, 1'b0, 1'b0);
        check("R5", "unrelated event holds stage", int'(cur_stage), 1);
        send(1, 1'b0, 1'b0);
        check("R4", "advance to stage 2", int'(cur_stage), 2);
        check("R4", "no early fire", int'(cap_start), 0);
        send(0, 1'b0, 1'b0);
        check("R5", "stage 0 match restarts at 1", int'(cur_stage), 1);
        send(1, 1'b0, 1'b0);
        send(6, 1'b0, 1'b0);
        check("R4", "fire on last stage", int'(cap_start), 1);
        check("R4", "stage back to 0 after fire", int'(cur_stage), 0);
        wait_idle();
    endtask

    task automatic t_errors();
        clear_stages();
        cfg_mode = 1'b1;
        cfg_last_stage = SW'(1);
        set_stage(0, 2, 6'h3F, 1'b1, 1'b0, 1'b0);
        set_stage(1, 0, 6'h3F, 1'b0, 1'b0, 1'b1);
        do_arm();
        send(2, 1'b0, 1'b0);
        check("R6", "stage 1 reached", int'(cur_stage), 1);
        send(0, 1'b0, 1'b0);
        check("R6", "cmd compare disabled on crc stage", int'(cap_start), 0);
        send(3, 1'b0, 1'b1);
        check("R6", "crc error fires", int'(cap_start), 1);
        wait_idle();
        clear_stages();
        cfg_mode = 1'b0;
        set_stage(0, 0, 6'h00, 1'b0, 1'b1, 1'b0);
        do_arm();
        send(7, 1'b0, 1'b1);
        check("R6", "crc flag ignored on response stage", int'(cap_start), 0);
        send(7, 1'b1, 1'b0);
        check("R6", "bad response fires", int'(cap_start), 1);
        wait_idle();
    endtask

    task automatic t_rearm();
        clear_stages();
        cfg_mode = 1'b0;
        set_stage(0, 1, 6'h3F, 1'b1, 1'b0, 1'b0);
        do_arm();
        send(1, 1'b0, 1'b0);
        check("R9", "fire before blocked arm", int'(cap_start), 1);
        do_arm();
        wait_idle();
        send(1, 1'b0, 1'b0);
        check("R9", "arm during pulse ignored", int'(cap_start), 0);
        do_arm();
        send(1, 1'b0, 1'b0);
        check("R9", "arm after pulse works", int'(cap_start), 1);
        wait_idle();
    endtask

    task automatic t_single_stage_only();
        clear_stages();
        cfg_mode = 1'b0;
        cfg_last_stage = SW'(2);
        set_stage(0, 0, 6'h3F, 1'b1, 1'b0, 1'b0);
        set_stage(1, 1, 6'h3F, 1'b1, 1'b0, 1'b0);
        do_arm();
        send(1, 1'b0, 1'b0);
        check("R10", "stage stays 0 in single mode", int'(cur_stage), 0);
        send(0, 1'b0, 1'b0);
        check("R2", "single mode fires on stage 0 alone", int'(cap_start), 1);
        check("R10", "stage 0 after single fire", int'(cur_stage), 0);
        wait_idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_mask();
        t_sequence();
        t_errors();
        t_rearm();
        t_single_stage_only();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule